// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives a stereo serial audio stream as a slave. A bit clock, a word clock that separates the left and right channels, and one serial data line arrive from outside. All three are brought into the system clock domain. Each rising bit-clock edge captures one data bit. The block recovers one left and one right two's-complement sample per frame, in one of five framings. It presents each complete stereo pair on two parallel 24-bit outputs, together with a one-cycle valid strobe.

The framing is chosen by a 3-bit code. The code is sampled only while the synchronous reset is asserted, and the value present at reset release stays in force until the next reset. Every sample is delivered sign-extended to 24 bits. The system clock must run at least eight times faster than the bit clock.

Top module: `sar_rx`

## Requirements
- R1: While reset is low and after its release, until the first complete pair, `out_valid` is 0 and `out_left`/`out_right` are 0.
- R2: `fmt_sel` is sampled only while `rst_n` is low. A change of `fmt_sel` after release has no effect on the recovered samples.
- R3: Code 000 is right-justified 16-bit. The LSB is in the last bit slot of a half frame, earlier slots are ignored, and the 16-bit word is sign-extended to 24 bits.
- R4: Code 001 is right-justified 20-bit (the LSB is in the last slot) and works with 20 slots per half frame. The word is sign-extended from bit 19.
- R5: Code 100 is right-justified 24-bit (the LSB is in the last slot) and works with 24 slots per half frame.
- R6: Code 010 is left-justified 20-bit. The MSB is in the first slot after a word-clock change, and slots after the 20th are ignored.
- R7: Code 011 is I2S. The MSB is one slot after the word-clock change, and a low word clock marks the left channel. With 16 slots per half frame, the 16 received bits form bits 19..4 of a 20-bit word with zero low bits. That word is then sign-extended.
- R8: In codes 000, 001, 010 and 100, a high word clock marks the left channel. Each pair is output with `out_valid` high for exactly one cycle, after the right half completes. The outputs hold their values between strobes.
- R9: The half frame in progress at reset release is discarded. A right half with no preceding left half produces no pair.
- R10: Codes 101, 110 and 111 produce no output: `out_valid` stays 0.
- R11: Data is MSB first in every mode and is captured on the rising bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; format sampled while low |
| fmt_sel | input | 3 | Framing code |
| sck_in | input | 1 | Serial bit clock |
| ws_in | input | 1 | Word clock (channel select) |
| sd_in | input | 1 | Serial data |
| out_valid | output | 1 | One-cycle strobe for a new pair |
| out_left | output | 24 | Left sample, sign-extended |
| out_right | output | 24 | Right sample, sign-extended |

## Verification
Suppose the shift register or the left-justified counter holds a wrong bit or count. The error then appears as a wrong value on the very next strobe, one half frame after the fault. If the frame tracker takes the wrong channel polarity or the wrong start, whole pairs are missing, duplicated or swapped, and the pair count differs from the count sent. If the latched format or the channel pairing is wrong, the output values are wrong from the first strobe.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int SAMPLE_W = 24;
    localparam int LJ_W     = 20;
    localparam int RJ_SHORT = 16;
    localparam int RJ_MID   = 20;

    typedef enum logic [2:0] {
        FMT_RJ16 = 3'b000,
        FMT_RJ20 = 3'b001,
        FMT_LJ20 = 3'b010,
        FMT_I2S  = 3'b011,
        FMT_RJ24 = 3'b100
    } fmt_e;

    function automatic logic fmt_known(input logic [2:0] code);
        return code <= 3'b100;
    endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise_o,
    output logic ws_o,
    output logic sd_o
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] ws;
        logic [STAGES-1:0] sd;
        logic              sck_last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sck      = {st_q.sck[STAGES-2:0], sck_i};
        st_d.ws       = {st_q.ws[STAGES-2:0], ws_i};
        st_d.sd       = {st_q.sd[STAGES-2:0], sd_i};
        st_d.sck_last = st_q.sck[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sck[STAGES-1] & ~st_q.sck_last;
    assign ws_o   = st_q.ws[STAGES-1];
    assign sd_o   = st_q.sd[STAGES-1];
endmodule

// File: rtl/sar_frame.sv
module sar_frame (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic ws_i,
    input  logic i2s_i,
    output logic edge_o,
    output logic close_o,
    output logic left_o
);
    typedef struct packed {
        logic       ws1;
        logic       ws2;
        logic [1:0] prime;
        logic       started;
    } st_t;

    st_t  st_d, st_q;
    logic cur_w, prev_w, primed;

    always_comb begin
        st_d   = st_q;
        cur_w  = i2s_i ? st_q.ws1 : ws_i;
        prev_w = i2s_i ? st_q.ws2 : st_q.ws1;
        primed = i2s_i ? (st_q.prime == 2'd2) : (st_q.prime != 2'd0);
        edge_o = rise_i && primed && (cur_w != prev_w);
        if (rise_i) begin
            st_d.ws1 = ws_i;
            st_d.ws2 = st_q.ws1;
            if (st_q.prime != 2'd2) st_d.prime = st_q.prime + 2'd1;
        end
        if (edge_o) st_d.started = 1'b1;
        close_o = edge_o && st_q.started;
        left_o  = i2s_i ? ~prev_w : prev_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sar_word.sv
module sar_word
    import sar_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int LW = LJ_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_i,
    input  logic          bit_i,
    input  logic          edge_i,
    input  logic [2:0]    fmt_i,
    output logic [SW-1:0] sample_o
);
    localparam int CW = $clog2(LW + 1);

    typedef struct packed {
        logic [SW-1:0] sr;
        logic [LW-1:0] acc;
        logic [CW-1:0] cnt;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] shamt;
    logic [LW-1:0] aligned;

    always_comb begin
        shamt   = CW'(LW) - st_q.cnt;
        aligned = st_q.acc << shamt;
        case (fmt_i)
            FMT_RJ16: sample_o = {{(SW-RJ_SHORT){st_q.sr[RJ_SHORT-1]}}, st_q.sr[RJ_SHORT-1:0]};
            FMT_RJ20: sample_o = {{(SW-RJ_MID){st_q.sr[RJ_MID-1]}}, st_q.sr[RJ_MID-1:0]};
            FMT_RJ24: sample_o = st_q.sr;
            default:  sample_o = {{(SW-LW){aligned[LW-1]}}, aligned};
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            st_d.sr = {st_q.sr[SW-2:0], bit_i};
            if (edge_i) begin
                st_d.acc = LW'(bit_i);
                st_d.cnt = CW'(1);
            end else if (st_q.cnt < CW'(LW)) begin
                st_d.acc = {st_q.acc[LW-2:0], bit_i};
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the left-justified bit count never passes the word width
    p_acc_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(LW));
endmodule

// File: rtl/sar_rx.sv
module sar_rx
    import sar_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  fmt_sel,
    input  logic        sck_in,
    input  logic        ws_in,
    input  logic        sd_in,
    output logic        out_valid,
    output logic [23:0] out_left,
    output logic [23:0] out_right
);
    typedef struct packed {
        logic [2:0]          fmt;
        logic                have_left;
        logic [SAMPLE_W-1:0] left_hold;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
        logic                out_v;
    } st_t;

    st_t                 st_d, st_q;
    logic                rise, ws_s, sd_s;
    logic                half_edge, half_close, half_left;
    logic [SAMPLE_W-1:0] word;

    sar_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_in), .ws_i(ws_in), .sd_i(sd_in),
        .rise_o(rise), .ws_o(ws_s), .sd_o(sd_s)
    );

    sar_frame frame_i (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .ws_i(ws_s),
        .i2s_i(st_q.fmt == FMT_I2S),
        .edge_o(half_edge), .close_o(half_close), .left_o(half_left)
    );

    sar_word #(.SW(SAMPLE_W), .LW(LJ_W)) word_i (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .bit_i(sd_s),
        .edge_i(half_edge), .fmt_i(st_q.fmt), .sample_o(word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.out_v = 1'b0;
        if (fmt_known(st_q.fmt) && half_close) begin
            if (half_left) begin
                st_d.left_hold = word;
                st_d.have_left = 1'b1;
            end else if (st_q.have_left) begin
                st_d.out_l     = st_q.left_hold;
                st_d.out_r     = word;
                st_d.out_v     = 1'b1;
                st_d.have_left = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fmt <= fmt_sel;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_v;
    assign out_left  = st_q.out_l;
    assign out_right = st_q.out_r;

    // R8: strobe lasts one cycle
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: outputs hold between strobes
    p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_left) && $stable(out_right)));

    // R10: reserved codes stay silent
    p_reserved_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_known(st_q.fmt) |-> !out_valid);

    // R3: 16-bit samples arrive sign-extended
    p_sext16_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.fmt == FMT_RJ16) |->
        ((&out_left[23:15] || ~|out_left[23:15]) &&
         (&out_right[23:15] || ~|out_right[23:15])));
endmodule

// File: tb/sar_rx_tb_top.sv
module sar_rx_tb_top;
    localparam int CLK_P    = 10;
    localparam int HALF_SCK = 4;
    localparam int MAXS     = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_sel = 3'b000;
    logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic        out_valid;
    logic [23:0] out_left, out_right;

    always #(CLK_P/2) clk = ~clk;

    sar_rx dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .sck_in(sck), .ws_in(ws),
        .sd_in(sd), .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    int n_chk = 0, n_fail = 0;
    int got_n = 0, dbl = 0;
    logic prev_v = 1'b0;
    logic [23:0] got_l [0:7];
    logic [23:0] got_r [0:7];
    logic [23:0] lw [0:7];
    logic [23:0] rw [0:7];
    logic ws_a [0:MAXS-1];
    logic sd_a [0:MAXS-1];
    int   n_slots = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_v = 1'b0;
        end else begin
            if (out_valid) begin
                if (got_n < 8) begin
                    got_l[got_n] = out_left;
                    got_r[got_n] = out_right;
                end
                got_n++;
            end
            if (out_valid && prev_v) dbl++;
            prev_v = out_valid;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int width_of(input logic [2:0] f, input int b);
        case (f)
            3'b000:  return 16;
            3'b001:  return 20;
            3'b100:  return 24;
            default: return (b < 20) ? b : 20;
        endcase
    endfunction

    function automatic int offset_of(input logic [2:0] f, input int b);
        case (f)
            3'b010:  return 0;
            3'b011:  return 1;
            default: return b - width_of(f, b);
        endcase
    endfunction

    function automatic logic [23:0] exp_val(input logic [2:0] f, input int b, input logic [23:0] w);
        logic [19:0] t;
        case (f)
            3'b000: return {{8{w[15]}}, w[15:0]};
            3'b001: return {{4{w[19]}}, w[19:0]};
            3'b100: return w;
            default: begin
                t = (b < 20) ? {w[15:0], 4'b0000} : w[19:0];
                return {{4{t[19]}}, t};
            end
        endcase
    endfunction

    task automatic do_reset(input logic [2:0] f);
        @(negedge clk);
        rst_n = 1'b0; fmt_sel = f; sck = 1'b0; ws = 1'b0; sd = 1'b0;
        repeat (5) @(negedge clk);
        got_n = 0; dbl = 0;
        rst_n = 1'b1;
    endtask

    // halves: left junk, right junk, p pairs, trailing left junk
    task automatic build(input logic [2:0] f, input int b, input int p);
        logic lws;
        lws = (f == 3'b011) ? 1'b0 : 1'b1;
        n_slots = (2*p + 3) * b;
        for (int g = 0; g < n_slots; g++) begin
            sd_a[g] = g[0] ^ g[2] ^ g[4];
            ws_a[g] = (((g / b) % 2) == 0) ? lws : ~lws;
        end
        for (int i = 0; i < p; i++) begin
            for (int ch = 0; ch < 2; ch++) begin
                int st;
                int wd;
                logic [23:0] wv;
                st = (2 + 2*i + ch) * b + offset_of(f, b);
                wd = width_of(f, b);
                wv = (ch == 1) ? rw[i] : lw[i];
                for (int k = 0; k < wd; k++) sd_a[st + k] = wv[wd-1-k];
            end
        end
    endtask

    task automatic play();
        for (int g = 0; g < n_slots; g++) begin
            ws = ws_a[g]; sd = sd_a[g];
            repeat (HALF_SCK) @(negedge clk);
            sck = 1'b1;
            repeat (HALF_SCK) @(negedge clk);
            sck = 1'b0;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic verify(input logic [2:0] f, input int b, input int p, input string tag);
        check(got_n == p, {tag, " pair count R8 R9"}, 24'(got_n), 24'(p));
        check(dbl == 0, {tag, " single-cycle strobe R8"}, 24'(dbl), 24'd0);
        for (int i = 0; i < p && i < got_n && i < 8; i++) begin
            check(got_l[i] == exp_val(f, b, lw[i]), {tag, " left R11"}, got_l[i], exp_val(f, b, lw[i]));
            check(got_r[i] == exp_val(f, b, rw[i]), {tag, " right R11"}, got_r[i], exp_val(f, b, rw[i]));
        end
    endtask

    task automatic run(input logic [2:0] f, input int b, input int p, input string tag);
        do_reset(f);
        build(f, b, p);
        play();
        verify(f, b, p, tag);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", 24'(out_valid), 24'd0);
        check(out_left == 24'd0, "R1 left in reset", out_left, 24'd0);
        check(out_right == 24'd0, "R1 right in reset", out_right, 24'd0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(out_valid == 1'b0 && out_left == 24'd0, "R1 idle after release", out_left, 24'd0);
    endtask

    task automatic t_rj16();
        run(3'b000, 32, 3, "R3 rj16 64fs");
        run(3'b000, 16, 2, "R3 rj16 32fs");
    endtask

    task automatic t_rj20();
        run(3'b001, 20, 2, "R4 rj20 40fs");
        run(3'b001, 32, 2, "R4 rj20 64fs");
    endtask

    task automatic t_rj24();
        run(3'b100, 24, 2, "R5 rj24 48fs");
        run(3'b100, 32, 3, "R5 rj24 64fs");
    endtask

    task automatic t_lj20();
        run(3'b010, 32, 3, "R6 lj20 64fs");
        run(3'b010, 20, 2, "R6 lj20 40fs");
    endtask

    task automatic t_i2s();
        run(3'b011, 32, 3, "R7 i2s 64fs");
        run(3'b011, 16, 2, "R7 i2s 32fs");
    endtask

    task automatic t_fmt_change();
        do_reset(3'b000);
        @(negedge clk);
        fmt_sel = 3'b010;
        build(3'b000, 32, 2);
        play();
        verify(3'b000, 32, 2, "R2 format held after release");
    endtask

    task automatic t_reserved();
        do_reset(3'b101);
        build(3'b000, 32, 2);
        play();
        check(got_n == 0, "R10 code 101 silent", 24'(got_n), 24'd0);
        do_reset(3'b111);
        build(3'b010, 32, 2);
        play();
        check(got_n == 0, "R10 code 111 silent", 24'(got_n), 24'd0);
        check(out_left == 24'd0, "R10 outputs untouched", out_left, 24'd0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        lw[0] = 24'h800001; rw[0] = 24'h7FFFFE;
        lw[1] = 24'h123456; rw[1] = 24'hFEDCBA;
        lw[2] = 24'hA5A5A5; rw[2] = 24'h0F0F0F;
        for (int i = 3; i < 8; i++) begin
            lw[i] = 24'(i * 24'h111111);
            rw[i] = ~lw[i];
        end
        t_reset_state();
        t_rj16();
        t_rj20();
        t_rj24();
        t_lj20();
        t_i2s();
        t_fmt_change();
        t_reserved();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule